// File: doc/BRIEF.md
# Packet-Driven Configuration Register Port

This block turns a byte stream of register-access packets from a serial display link into reads and writes of a bank of 32-bit configuration registers. Each packet starts with a data-type byte flagged by `in_first`. A 16-bit payload length follows, least-significant byte first, and then the payload bytes. A write packet carries a register address and one or more data words. The address steps by 4 for each extra word, so a single packet can fill a run of consecutive registers. A read packet carries only an address. It produces a four-byte response on a separate output byte stream.

The register bank has `NUM_REGS` word registers starting at `BASE_ADDR` (by default 0x0450 to 0x046C). A fixed identifier can be read at 0x0580. A write to 0x0504 whose low data byte is 0xFF clears the whole bank. Every accepted write word also appears for one cycle on a write bus, so neighbouring logic can follow configuration changes.

Top module: `cfg_packet_port`

## Requirements
- R1: After reset, `rsp_valid`, `wr_en`, `len_err` and `soft_rst` are low and every bank register reads as zero.
- R2: A byte with `in_valid` and `in_first` high is the data type. The next two accepted bytes are the payload length, low byte first, and the payload follows. Cycles with `in_valid` low are skipped. A new `in_first` byte abandons any packet in progress. Bytes beyond the stated length are ignored until the next `in_first` byte.
- R3: Data type 0x29 is a write. Payload bytes 0 and 1 are the address, low byte first. Each following group of four bytes is one data word, low byte first, and is written to the current address. `wr_en` pulses with `wr_addr` and `wr_data` in the cycle after the word's fourth byte is accepted.
- R4: Each further data word in the same write packet goes to the previous address plus 4.
- R5: Data type 0x24 is a read, and payload bytes 0 and 1 are the address. Starting in the cycle after the second address byte is accepted, `rsp_valid` is high for exactly 4 consecutive cycles. `rsp_byte` carries the register value, low byte first.
- R6: Address 0x0580 always reads 0x00006500. Writes to it change nothing and produce no `wr_en` pulse.
- R7: A read of an address outside the bank, or of a bank address whose two low bits are not zero, returns 0.
- R8: A packet of any other data type produces no write, no response and no error.
- R9: At the end of a write packet, if the length is below 2 or (length − 2) is not a multiple of 4, `len_err` pulses for one cycle. The trailing partial word is discarded, and the complete words of that packet are still written.
- R10: A word written to 0x0504 with low byte 0xFF clears every bank register and pulses `soft_rst` together with its `wr_en`. Any other low byte clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_first | input | 1 | Input byte is a packet's data type |
| in_byte | input | 8 | Input byte |
| rsp_valid | output | 1 | Response byte present |
| rsp_byte | output | 8 | Read response byte, low byte first |
| wr_en | output | 1 | One-cycle pulse per accepted write word |
| wr_addr | output | 16 | Address of the accepted write word |
| wr_data | output | 32 | Value of the accepted write word |
| len_err | output | 1 | One-cycle pulse on a malformed write length |
| soft_rst | output | 1 | One-cycle pulse when the bank is cleared by a write |

## Verification
The bound checker enforces several rules on every cycle:
- the identifier address never appears on the write bus;
- a `soft_rst` pulse is always matched by a qualifying write on that bus;
- a response burst is always exactly four bytes long;
- write and error pulses only ever follow an accepted payload byte.

Other behaviour can only be shown through the bench's scenarios:
- whether stored values, little-endian byte order and address stepping are correct;
- that foreign data types and over-length bytes are dropped;
- that the bank is cleared;
- that the error pulse appears for each payload length in a sweep.

// File: rtl/cfg_packet_port.sv
module cfg_packet_port #(
  parameter logic [15:0] BASE_ADDR = 16'h0450,
  parameter int          NUM_REGS  = 8,
  parameter logic [15:0] ID_ADDR   = 16'h0580,
  parameter logic [31:0] ID_VALUE  = 32'h0000_6500,
  parameter logic [15:0] RST_ADDR  = 16'h0504,
  parameter logic [7:0]  DT_WRITE  = 8'h29,
  parameter logic [7:0]  DT_READ   = 8'h24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_first,
  input  logic [7:0]  in_byte,
  output logic        rsp_valid,
  output logic [7:0]  rsp_byte,
  output logic        wr_en,
  output logic [15:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        len_err,
  output logic        soft_rst
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [16:0] END_ADDR = 17'(BASE_ADDR) + 17'(4 * NUM_REGS);

  typedef enum logic [1:0] {S_IDLE, S_LEN0, S_LEN1, S_PAY} st_t;

  st_t         st;
  logic [7:0]  dtype;
  logic [15:0] len, cnt, addr;
  logic [23:0] part;
  logic [31:0] regs [NUM_REGS];
  logic [31:0] rsp_sh;
  logic [2:0]  rsp_cnt;

  function automatic logic in_bank(input logic [15:0] a);
    return (a[1:0] == 2'b00) && (a >= BASE_ADDR) && (17'(a) < END_ADDR);
  endfunction

  function automatic logic [IW-1:0] bank_idx(input logic [15:0] a);
    return IW'((a - BASE_ADDR) >> 2);
  endfunction

  wire        take      = in_valid && !in_first;
  wire        in_pay    = take && (st == S_PAY);
  wire        is_wr     = (dtype == DT_WRITE);
  wire        is_rd     = (dtype == DT_READ);
  wire        last      = in_pay && (cnt + 16'd1 == len);
  wire [1:0]  dpos      = cnt[1:0] - 2'd2;
  wire        word_done = in_pay && is_wr && (cnt >= 16'd2) && (dpos == 2'd3);
  wire        rd_go     = in_pay && is_rd && (cnt == 16'd1);
  wire [31:0] wr_word   = {in_byte, part};
  wire        clear_hit = word_done && (addr == RST_ADDR) && (part[7:0] == 8'hFF);
  wire        len_bad   = (len < 16'd2) || (len[1:0] != 2'b10);
  wire [15:0] rd_addr   = {in_byte, addr[7:0]};

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (rd_addr == ID_ADDR) rd_val = ID_VALUE;
    else if (in_bank(rd_addr)) rd_val = regs[bank_idx(rd_addr)];
  end

  assign rsp_valid = (rsp_cnt != 3'd0);
  assign rsp_byte  = rsp_sh[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dtype    <= '0;
      len      <= '0;
      cnt      <= '0;
      addr     <= '0;
      part     <= '0;
      rsp_sh   <= '0;
      rsp_cnt  <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      len_err  <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      len_err  <= 1'b0;
      soft_rst <= 1'b0;
      if (rsp_cnt != 3'd0) begin
        rsp_sh  <= rsp_sh >> 8;
        rsp_cnt <= rsp_cnt - 3'd1;
      end
      if (in_valid && in_first) begin
        dtype <= in_byte;
        st    <= S_LEN0;
      end else if (take) begin
        case (st)
          S_LEN0: begin
            len[7:0] <= in_byte;
            st       <= S_LEN1;
          end
          S_LEN1: begin
            len[15:8] <= in_byte;
            cnt       <= '0;
            if ({in_byte, len[7:0]} == 16'd0) begin
              st <= S_IDLE;
              if (is_wr) len_err <= 1'b1;
            end else begin
              st <= S_PAY;
            end
          end
          S_PAY: begin
            cnt <= cnt + 16'd1;
            if (cnt == 16'd0) addr[7:0] <= in_byte;
            else if (cnt == 16'd1) addr[15:8] <= in_byte;
            else if (is_wr && dpos != 2'd3) part[{dpos, 3'b000} +: 8] <= in_byte;
            if (last) begin
              st <= S_IDLE;
              if (is_wr && len_bad) len_err <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (rd_go) begin
        rsp_sh  <= rd_val;
        rsp_cnt <= 3'd4;
      end
      if (word_done) begin
        addr <= addr + 16'd4;
        if (addr != ID_ADDR) begin
          wr_en   <= 1'b1;
          wr_addr <= addr;
          wr_data <= wr_word;
        end
        if (clear_hit) soft_rst <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (word_done) begin
      if (clear_hit) begin
        for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else if (in_bank(addr)) begin
        regs[bank_idx(addr)] <= wr_word;
      end
    end
  end
endmodule

// File: rtl/cfg_packet_port_chk.sv
module cfg_packet_port_chk #(
  parameter logic [15:0] ID_ADDR  = 16'h0580,
  parameter logic [15:0] RST_ADDR = 16'h0504
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_first,
  input logic        rsp_valid,
  input logic        wr_en,
  input logic [15:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        len_err,
  input logic        soft_rst
);
  logic [2:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (rsp_valid) run <= run + 3'd1;
    else run <= '0;
  end

  p_id_not_on_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr != ID_ADDR));

  p_soft_rst_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (wr_en && wr_addr == RST_ADDR && wr_data[7:0] == 8'hFF));

  p_rsp_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (run < 3'd4));

  p_rsp_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && run != 3'd0) |-> (run == 3'd4));

  p_wr_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid && !in_first));

  p_err_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> $past(in_valid && !in_first));
endmodule

bind cfg_packet_port cfg_packet_port_chk #(.ID_ADDR(ID_ADDR), .RST_ADDR(RST_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
  .rsp_valid(rsp_valid), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .len_err(len_err), .soft_rst(soft_rst)
);

// File: tb/cfg_packet_port_test.sv
module cfg_packet_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h0450;
  localparam int NREG = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0;
  logic [7:0] in_byte = '0;
  logic rsp_valid, wr_en, len_err, soft_rst;
  logic [7:0] rsp_byte;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;

  cfg_packet_port uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first), .in_byte(in_byte),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .len_err(len_err), .soft_rst(soft_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int wr_cnt = 0, err_cnt = 0, srst_cnt = 0, rsp_n = 0;
  logic [15:0] last_wa = '0;
  logic [31:0] last_wd = '0, rsp_word = '0;
  logic [31:0] model [NREG];
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
      if (len_err) err_cnt++;
      if (soft_rst) srst_cnt++;
      if (rsp_valid) begin rsp_word = {rsp_byte, rsp_word[31:8]}; rsp_n++; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit bank(input logic [15:0] a);
    return a[1:0] == 2'b00 && a >= BASE && a < BASE + 16'(4 * NREG);
  endfunction

  function automatic logic [31:0] mexp(input logic [15:0] a);
    if (a == 16'h0580) return 32'h0000_6500;
    if (bank(a)) return model[(a - BASE) >> 2];
    return 32'h0;
  endfunction

  function automatic logic [31:0] val(input logic [15:0] a, input int s);
    return {a ^ 16'h5A5A, 8'(s), 8'(a[9:2]) ^ 8'h3C};
  endfunction

  task automatic put(input logic f, input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_first = f; in_byte = b;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); in_valid = 1'b0; in_first = 1'b0; end
  endtask

  task automatic model_write(input logic [15:0] a, input logic [31:0] d);
    if (a == 16'h0504 && d[7:0] == 8'hFF) begin
      for (int i = 0; i < NREG; i++) model[i] = '0;
    end else if (bank(a)) model[(a - BASE) >> 2] = d;
  endtask

  task automatic rd_chk(input logic [15:0] a, input string tag);
    int n0 = rsp_n;
    logic [31:0] e = mexp(a);
    put(1, 8'h24); put(0, 8'd2); put(0, 8'd0); put(0, a[7:0]); put(0, a[15:8]);
    @(negedge clk); in_valid = 1'b0; in_first = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_byte === e[7:0], {tag, " R5 first byte timing"}, {23'd0, rsp_valid, rsp_byte}, {24'd1, e[7:0]});
    idle(5);
    chk(rsp_n - n0 == 4, {tag, " R5 byte count"}, 32'(rsp_n - n0), 32'd4);
    chk(rsp_word === e, $sformatf("%s read %h", tag, a), rsp_word, e);
  endtask

  task automatic wr_word1(input logic [15:0] a, input logic [31:0] d, input string tag);
    put(1, 8'h29); put(0, 8'd6); put(0, 8'd0); put(0, a[7:0]); put(0, a[15:8]);
    put(0, d[7:0]); put(0, d[15:8]); put(0, d[23:16]); put(0, d[31:24]);
    @(negedge clk); in_valid = 1'b0;
    if (a != 16'h0580)
      chk(wr_en === 1'b1 && wr_addr === a && wr_data === d, {tag, " R3 write bus"}, wr_data, d);
    else
      chk(wr_en === 1'b0, {tag, " R6 no bus write"}, {31'd0, wr_en}, 32'd0);
    @(negedge clk);
    chk(wr_en === 1'b0, {tag, " R3 single pulse"}, {31'd0, wr_en}, 32'd0);
    idle(1);
    if (a != 16'h0580) model_write(a, d);
  endtask

  task automatic wr_pkt(input logic [15:0] a, input int extra, input int s, input bit gap);
    logic [15:0] ln = 16'(2 + extra);
    put(1, 8'h29); put(0, ln[7:0]); put(0, ln[15:8]); put(0, a[7:0]);
    if (gap) idle(2);
    put(0, a[15:8]);
    for (int k = 0; k < extra; k++) begin
      logic [31:0] w = val(a + 16'(4 * (k / 4)), s);
      put(0, 8'(w >> (8 * (k % 4))));
      if (gap && k == 1) idle(3);
    end
    idle(2);
    for (int k = 0; k < extra / 4; k++) model_write(a + 16'(4 * k), val(a + 16'(4 * k), s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int w0, e0, s0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({rsp_valid, wr_en, len_err, soft_rst} === 4'b0, "R1 outputs idle", {28'd0, rsp_valid, wr_en, len_err, soft_rst}, 32'd0);
    for (int i = 0; i < NREG; i++) rd_chk(BASE + 16'(4 * i), "R1 reset value");

    // R6 identifier
    rd_chk(16'h0580, "R6 id");
    w0 = wr_cnt;
    wr_word1(16'h0580, 32'h1234_5678, "R6 id write");
    chk(wr_cnt == w0, "R6 write count", 32'(wr_cnt), 32'(w0));
    rd_chk(16'h0580, "R6 id after write");

    // R3 single-word writes to every register
    for (int i = 0; i < NREG; i++) wr_word1(BASE + 16'(4 * i), val(BASE + 16'(4 * i), 1), "R3");
    for (int i = 0; i < NREG; i++) rd_chk(BASE + 16'(4 * i), "R3 readback");

    // R4 multi-word burst across whole bank
    w0 = wr_cnt;
    wr_pkt(BASE, 4 * NREG, 2, 0);
    chk(wr_cnt - w0 == NREG, "R4 burst word count", 32'(wr_cnt - w0), 32'(NREG));
    chk(last_wa === BASE + 16'(4 * (NREG - 1)), "R4 last address", {16'd0, last_wa}, {16'd0, BASE + 16'(4 * (NREG - 1))});
    for (int i = 0; i < NREG; i++) rd_chk(BASE + 16'(4 * i), "R4 readback");

    // R9 length sweep
    for (int x = 0; x < 12; x++) begin
      w0 = wr_cnt; e0 = err_cnt;
      wr_pkt(BASE + 16'd8, x, 10 + x, 0);
      chk(wr_cnt - w0 == x / 4, $sformatf("R9 words len+%0d", x), 32'(wr_cnt - w0), 32'(x / 4));
      chk(err_cnt - e0 == ((x % 4) != 0 ? 1 : 0), $sformatf("R9 error len+%0d", x), 32'(err_cnt - e0), 32'((x % 4) != 0));
      for (int i = 0; i < NREG; i++) rd_chk(BASE + 16'(4 * i), "R9 bank intact");
    end
    e0 = err_cnt;
    put(1, 8'h29); put(0, 8'd0); put(0, 8'd0); idle(2);
    chk(err_cnt - e0 == 1, "R9 zero-length write", 32'(err_cnt - e0), 32'd1);
    e0 = err_cnt;
    put(1, 8'h29); put(0, 8'd1); put(0, 8'd0); put(0, 8'h50); idle(2);
    chk(err_cnt - e0 == 1, "R9 one-byte write", 32'(err_cnt - e0), 32'd1);

    // R7 unmapped and misaligned reads
    rd_chk(16'h0000, "R7");
    rd_chk(16'h0400, "R7");
    rd_chk(BASE + 16'(4 * NREG), "R7");
    rd_chk(BASE + 16'd2, "R7 misaligned");
    rd_chk(16'hFFFC, "R7");
    rd_chk(16'h0504, "R7");

    // R8 foreign data types
    w0 = wr_cnt; e0 = err_cnt;
    foreach (model[i]) ;
    for (int t = 0; t < 3; t++) begin
      logic [7:0] dt = (t == 0) ? 8'h39 : (t == 1) ? 8'h05 : 8'h28;
      put(1, dt); put(0, 8'd6); put(0, 8'd0); put(0, BASE[7:0]); put(0, BASE[15:8]);
      put(0, 8'hDE); put(0, 8'hAD); put(0, 8'hBE); put(0, 8'hEF); idle(6);
    end
    chk(wr_cnt == w0 && err_cnt == e0 && rsp_n % 4 == 0, "R8 no effect", 32'(wr_cnt - w0), 32'd0);
    rd_chk(BASE, "R8 bank unchanged");

    // R2 pause, abort and trailing bytes
    wr_pkt(BASE + 16'd16, 8, 40, 1);
    rd_chk(BASE + 16'd16, "R2 paused write");
    rd_chk(BASE + 16'd20, "R2 paused write");
    w0 = wr_cnt;
    put(1, 8'h29); put(0, 8'd6); put(0, 8'd0); put(0, 8'h54); put(0, 8'h04);
    put(0, 8'h11); put(0, 8'h22);
    rd_chk(BASE + 16'd4, "R2 abort by new packet");
    chk(wr_cnt == w0, "R2 aborted write", 32'(wr_cnt - w0), 32'd0);
    w0 = wr_cnt;
    wr_pkt(BASE + 16'd12, 4, 50, 0);
    put(0, 8'h77); put(0, 8'h66); put(0, 8'h55); put(0, 8'h44); idle(3);
    chk(wr_cnt - w0 == 1, "R2 trailing bytes ignored", 32'(wr_cnt - w0), 32'd1);
    for (int i = 0; i < NREG; i++) rd_chk(BASE + 16'(4 * i), "R2 bank");

    // R10 bank clear
    s0 = srst_cnt;
    wr_word1(16'h0504, 32'h0000_00FE, "R10 non-clear");
    chk(srst_cnt == s0, "R10 no clear on FE", 32'(srst_cnt - s0), 32'd0);
    rd_chk(BASE + 16'd8, "R10 kept");
    wr_word1(16'h0504, 32'h1234_00FF, "R10 clear");
    chk(srst_cnt - s0 == 1, "R10 clear pulse", 32'(srst_cnt - s0), 32'd1);
    for (int i = 0; i < NREG; i++) rd_chk(BASE + 16'(4 * i), "R10 cleared");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule